// File: doc/BRIEF.md
# Watchpoint Debug Event Arbiter

This block sits next to a load/store unit that issues one instruction as a train of memory beats. For every beat the unit reports whether a watchpoint matched, together with flags marking the first and the last beat of the instruction. The arbiter turns those match pulses into at most one debug action per instruction. The action is one of three: a one-cycle halt request, a one-cycle debug-exception request, or, for synchronous watchpoints, a retry request that restarts the whole instruction. Alongside the action it presents an entry-reason code, which stays stable until it is acknowledged.

Asynchronous hits are normally reported straight away. The exception is a hit that arrives from a middle beat of a multi-beat access to device-type or strongly-ordered memory. Such a hit is parked in one sticky state and released only when the last beat has completed, so that the instruction's accesses to ordered memory are never interrupted or repeated. While an event is parked, or being accepted, a grant output holds back any exception from a later instruction. The processor's abort mask and abort routing controls are wired in but have no influence on watchpoint events.

Top module: `wpa_top`

## Requirements
- R1: After reset, haltReq, dbgExcReq, retryReq and moeValid are 0, moeCode is 0, and laterExcGrant follows laterExcReq.
- R2: With asyncMode=0, a hit on any beat gives, in the cycle after that beat, a one-cycle request with retryReq=1 and moeCode=4'b1010.
- R3: With asyncMode=1, a hit on the first beat, on the last beat, or on any beat while devMem=0 gives, in the cycle after that beat, a one-cycle request with retryReq=0 and moeCode=4'b0010.
- R4: With asyncMode=1 and devMem=1, a hit on a beat that is neither first nor last gives no request until the cycle after the beat flagged last. It then gives one request with moeCode=4'b0010.
- R5: Every request goes to dbgExcReq when monitorSel=1 and to haltReq when monitorSel=0. The two are never high together, and each lasts one cycle.
- R6: abortMask and extAbortRoute change neither the timing nor the kind of any request.
- R7: moeValid rises together with the request and stays high, with moeCode unchanged, until ack. In the cycle after ack, moeValid and moeCode read 0.
- R8: Once a hit has been accepted, further hits up to ack merge into it and raise no second request.
- R9: While dbgEnable=0 or wpPermit=0, hits are dropped: no request, no retry, moeValid stays 0, and laterExcGrant is never withheld.
- R10: laterExcGrant is 0 while a deferred event is parked and in the cycle a hit is accepted. Otherwise it equals laterExcReq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| beatValid | input | 1 | A memory beat completes this cycle |
| beatFirst | input | 1 | Beat is the first of its instruction |
| beatLast | input | 1 | Beat is the last of its instruction |
| wpHit | input | 1 | Watchpoint matched on this beat |
| devMem | input | 1 | Access targets device-type or strongly-ordered memory |
| asyncMode | input | 1 | 1 = asynchronous watchpoint, 0 = synchronous |
| dbgEnable | input | 1 | Invasive debug enabled |
| wpPermit | input | 1 | Watchpoint events permitted |
| monitorSel | input | 1 | 1 = monitor mode (exception), 0 = halting mode |
| abortMask | input | 1 | Asynchronous abort mask (ignored by this block) |
| extAbortRoute | input | 1 | External abort routing (ignored by this block) |
| laterExcReq | input | 1 | A later instruction wants an exception accepted |
| ack | input | 1 | Acknowledge; clears the held event |
| haltReq | output | 1 | One-cycle halt request |
| dbgExcReq | output | 1 | One-cycle debug-exception (precise data abort) request |
| retryReq | output | 1 | One-cycle request to restart the whole instruction |
| moeValid | output | 1 | moeCode holds a reported event |
| moeCode | output | MOE_W | Entry-reason code |
| laterExcGrant | output | 1 | Later exception may be accepted |

## Verification
The bench builds the block with its default 4-bit entry-reason code and the two default code values. Because of that small configuration, every combination of the seven mode and control inputs can be swept. Each combination is run against instructions of one to four beats, with the hit on every possible beat, with and without further hits on the beats that follow. For every beat the bench works out from the requirements which cycle should carry the request, what kind of request it is, and when the grant must be withheld. This covers deferral from every middle position, first-beat and last-beat exemptions, single-beat accesses, and the merging of repeated hits.

// File: rtl/wpa_pkg.sv
package wpa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_DEFER    = 2'd1,
    ST_REPORTED = 2'd2
  } wpState_t;

  typedef struct packed {
    logic fire;      // report an event this cycle
    logic fireSync;  // the event is synchronous
    logic clear;     // drop held event
  } wpStrobe_t;
endpackage

// File: rtl/wpa_ctrl.sv
module wpa_ctrl
  import wpa_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      beatValid,
  input  logic      beatFirst,
  input  logic      beatLast,
  input  logic      wpHit,
  input  logic      devMem,
  input  logic      asyncMode,
  input  logic      dbgEnable,
  input  logic      wpPermit,
  input  logic      ack,
  input  logic      laterExcReq,
  output wpStrobe_t strb,
  output logic      busy,
  output logic      laterExcGrant
);
  wpState_t state, nxtState;
  logic enabled, hitNow, deferCond, accepting;

  assign enabled   = dbgEnable && wpPermit;
  assign hitNow    = enabled && beatValid && wpHit && !ack;
  assign deferCond = devMem && !beatFirst && !beatLast;
  assign accepting = (state == ST_IDLE) && hitNow;

  always_comb begin
    nxtState      = state;
    strb.fire     = 1'b0;
    strb.fireSync = 1'b0;
    strb.clear    = ack || !enabled;
    if (!enabled || ack) begin
      nxtState = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (hitNow) begin
            if (!asyncMode) begin
              strb.fire     = 1'b1;
              strb.fireSync = 1'b1;
              nxtState      = ST_REPORTED;
            end else if (deferCond) begin
              nxtState = ST_DEFER;
            end else begin
              strb.fire = 1'b1;
              nxtState  = ST_REPORTED;
            end
          end
        end
        ST_DEFER: begin
          if (beatValid && beatLast) begin
            strb.fire = 1'b1;
            nxtState  = ST_REPORTED;
          end
        end
        ST_REPORTED: nxtState = ST_REPORTED;
        default:     nxtState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxtState;
  end

  assign busy          = (state != ST_IDLE);
  assign laterExcGrant = laterExcReq && (state != ST_DEFER) && !accepting;

  // R10: a parked event blocks later exceptions
  a_r10_grant_held: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEFER) |-> !laterExcGrant);

  // R8: no second report while one is outstanding
  a_r8_single_report: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REPORTED) |-> !strb.fire);

  // R4: parked event waits for the last beat
  a_r4_wait_last: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEFER && !(beatValid && beatLast)) |=> (state != ST_REPORTED));
endmodule

// File: rtl/wpa_dp.sv
module wpa_dp
  import wpa_pkg::*;
#(
  parameter int MOE_W = 4,
  parameter logic [MOE_W-1:0] ASYNC_CODE = 4'b0010,
  parameter logic [MOE_W-1:0] SYNC_CODE  = 4'b1010
) (
  input  logic             clk,
  input  logic             rstN,
  input  wpStrobe_t        strb,
  input  logic             monitorSel,
  output logic             haltReq,
  output logic             dbgExcReq,
  output logic             retryReq,
  output logic             moeValid,
  output logic [MOE_W-1:0] moeCode
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      haltReq   <= 1'b0;
      dbgExcReq <= 1'b0;
      retryReq  <= 1'b0;
      moeValid  <= 1'b0;
      moeCode   <= '0;
    end else begin
      haltReq   <= strb.fire && !monitorSel;
      dbgExcReq <= strb.fire && monitorSel;
      retryReq  <= strb.fire && strb.fireSync;
      if (strb.clear) begin
        moeValid <= 1'b0;
        moeCode  <= '0;
      end else if (strb.fire) begin
        moeValid <= 1'b1;
        moeCode  <= strb.fireSync ? SYNC_CODE : ASYNC_CODE;
      end
    end
  end

  // R5: halt and exception never together
  a_r5_one_kind: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({haltReq, dbgExcReq}));

  // R5: requests are single-cycle pulses
  a_r5_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (haltReq || dbgExcReq) |=> !(haltReq || dbgExcReq));

  // R7: code held until acknowledged
  a_r7_moe_hold: assert property (@(posedge clk) disable iff (!rstN)
    (moeValid && !strb.clear) |=> (moeValid && $stable(moeCode)));
endmodule

// File: rtl/wpa_top.sv
module wpa_top
  import wpa_pkg::*;
#(
  parameter int MOE_W = 4,
  parameter logic [MOE_W-1:0] ASYNC_CODE = 4'b0010,
  parameter logic [MOE_W-1:0] SYNC_CODE  = 4'b1010
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             beatValid,
  input  logic             beatFirst,
  input  logic             beatLast,
  input  logic             wpHit,
  input  logic             devMem,
  input  logic             asyncMode,
  input  logic             dbgEnable,
  input  logic             wpPermit,
  input  logic             monitorSel,
  input  logic             abortMask,
  input  logic             extAbortRoute,
  input  logic             laterExcReq,
  input  logic             ack,
  output logic             haltReq,
  output logic             dbgExcReq,
  output logic             retryReq,
  output logic             moeValid,
  output logic [MOE_W-1:0] moeCode,
  output logic             laterExcGrant
);
  wpStrobe_t strb;
  logic busy;

  wpa_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .beatValid(beatValid), .beatFirst(beatFirst),
    .beatLast(beatLast), .wpHit(wpHit), .devMem(devMem), .asyncMode(asyncMode),
    .dbgEnable(dbgEnable), .wpPermit(wpPermit), .ack(ack),
    .laterExcReq(laterExcReq), .strb(strb), .busy(busy),
    .laterExcGrant(laterExcGrant)
  );

  wpa_dp #(.MOE_W(MOE_W), .ASYNC_CODE(ASYNC_CODE), .SYNC_CODE(SYNC_CODE)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .monitorSel(monitorSel),
    .haltReq(haltReq), .dbgExcReq(dbgExcReq), .retryReq(retryReq),
    .moeValid(moeValid), .moeCode(moeCode)
  );

  // R9: disabled cycles produce nothing
  a_r9_drop: assert property (@(posedge clk) disable iff (!rstN)
    !(dbgEnable && wpPermit) |=> !(haltReq || dbgExcReq || retryReq));

  // R2: retry comes with a request and the synchronous code
  a_r2_retry_kind: assert property (@(posedge clk) disable iff (!rstN)
    retryReq |-> ((haltReq || dbgExcReq) && moeCode == SYNC_CODE));

  // R6: mask and routing bits do not suppress an immediate asynchronous hit
  a_r6_not_masked: assert property (@(posedge clk) disable iff (!rstN)
    (dbgEnable && wpPermit && beatValid && wpHit && asyncMode && !devMem &&
     !ack && !busy && abortMask && extAbortRoute) |=> (haltReq || dbgExcReq));
endmodule

// File: tb/sim_wpa_top.sv
`timescale 1ns/1ps
module sim_wpa_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic beatValid = 0, beatFirst = 0, beatLast = 0, wpHit = 0;
  logic devMem = 0, asyncMode = 0, dbgEnable = 0, wpPermit = 0, monitorSel = 0;
  logic abortMask = 0, extAbortRoute = 0, laterExcReq = 0, ack = 0;
  logic haltReq, dbgExcReq, retryReq, moeValid, laterExcGrant;
  logic [3:0] moeCode;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  wpa_top u0 (
    .clk(clk), .rstN(rstN), .beatValid(beatValid), .beatFirst(beatFirst),
    .beatLast(beatLast), .wpHit(wpHit), .devMem(devMem), .asyncMode(asyncMode),
    .dbgEnable(dbgEnable), .wpPermit(wpPermit), .monitorSel(monitorSel),
    .abortMask(abortMask), .extAbortRoute(extAbortRoute),
    .laterExcReq(laterExcReq), .ack(ack), .haltReq(haltReq),
    .dbgExcReq(dbgExcReq), .retryReq(retryReq), .moeValid(moeValid),
    .moeCode(moeCode), .laterExcGrant(laterExcGrant)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one instruction of n beats, first hit on beat h, optional hits on all later beats
  task automatic runInstr(input int cfg, input int n, input int h, input bit extra);
    bit asy, dev, mon, en, deferred;
    int fireBeat;
    string tag;
    asy = cfg[0]; dev = cfg[1]; mon = cfg[2];
    en  = cfg[5] && cfg[6];
    deferred = asy && dev && h != 0 && h != n - 1;
    fireBeat = deferred ? n - 1 : h;
    if (!en) tag = "R9";
    else if (extra) tag = "R8";
    else if (!asy) tag = "R2/R6";
    else if (deferred) tag = "R4/R6";
    else tag = "R3/R6";
    for (int b = 0; b < n; b++) begin
      @(negedge clk);
      asyncMode = asy; devMem = dev; monitorSel = mon;
      abortMask = cfg[3]; extAbortRoute = cfg[4];
      dbgEnable = cfg[5]; wpPermit = cfg[6]; laterExcReq = 1'b1;
      beatValid = 1'b1; beatFirst = (b == 0); beatLast = (b == n - 1);
      wpHit = (b == h) || (extra && b > h);
      #1;
      chk("R10 grant", laterExcGrant, (en && b >= h && b <= fireBeat) ? 0 : 1);
      @(negedge clk);
      chk({tag, " R5 halt"}, haltReq, (en && b == fireBeat && !mon) ? 1 : 0);
      chk({tag, " R5 exc"}, dbgExcReq, (en && b == fireBeat && mon) ? 1 : 0);
      chk({tag, " retry"}, retryReq, (en && b == fireBeat && !asy) ? 1 : 0);
      if (en && b >= fireBeat)
        chk({tag, " R7 code"}, moeCode, asy ? 4'b0010 : 4'b1010);
      beatValid = 1'b0; wpHit = 1'b0; beatFirst = 1'b0; beatLast = 1'b0;
      #0;
    end
    chk({tag, " R7 valid"}, moeValid, en ? 1 : 0);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk("R7 ack clears valid", moeValid, 0);
    chk("R7 ack clears code", moeCode, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    laterExcReq = 1'b1;
    #1;
    chk("R1 grant in reset", laterExcGrant, 1);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 halt", haltReq, 0);
    chk("R1 exc", dbgExcReq, 0);
    chk("R1 retry", retryReq, 0);
    chk("R1 valid", moeValid, 0);
    chk("R1 code", moeCode, 0);
    for (int c = 0; c < 128; c++)
      for (int n = 1; n <= 4; n++)
        for (int h = 0; h < n; h++)
          for (int x = 0; x < 2; x++)
            runInstr(c, n, h, x[0]);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #700000;
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule